// File: doc/BRIEF.md
# DDC Display Presence Probe

This sequencer decides whether a monitor with a readable identification ROM is attached to a display data channel. A single-cycle request starts a probe. If the connector sits behind a port router, the sequencer first asks the external port-select logic to steer the router and waits for its acknowledge. It then drives a generic I2C master command interface. It sends a one-byte write of offset 0x00 to device 0x50, followed by an eight-byte read from the same device.

The eight returned bytes are compared with the fixed identification header 00 FF FF FF FF FF FF 00. The display counts as present when enough bytes match, six of eight by default, which tolerates corruption in two of the header bytes. Two I2C master channels are available: a plain bus and an auxiliary tunnel. The channel is chosen per probe, and only the chosen one is driven. The I2C bit engine and the router logic sit outside this block.

Top module: `ddc_presence_probe`

## Requirements
- R1: When router_valid_i is high at the request, sel_req_o rises and stays high until sel_ack_i; no I2C command start is issued on either channel before that acknowledge.
- R2: The probe issues exactly two commands. The first is a write (rd=0) with address 0x50, len 1 and wdata 0x00. Once the write completes without error, the second is a read (rd=1) with address 0x50 and len 8.
- R3: A command that completes with err high ends the probe with present_o=0. After a failed write, no read command is issued.
- R4: The expected header is byte0=0x00, bytes 1..6=0xFF, byte7=0x00. present_o=1 only when at least 6 received bytes equal their expected value; 5 or fewer give present_o=0.
- R5: If the read completes after fewer than 8 data bytes have arrived, the result is present_o=0.
- R6: use_aux_i is sampled with the request and selects the aux_* channel when 1 or the bus_* channel when 0. The unselected channel's outputs stay 0 and its done/err/rvalid inputs are ignored.
- R7: done_o is a one-cycle pulse at the end of each probe. present_o updates only together with done_o and holds its value until the next done_o.
- R8: probe_req_i is ignored while a probe is in progress.
- R9: rx_bytes_o holds received byte k at bits [8k+7:8k]. It is cleared when the read command starts.
- R10: After reset, done_o, present_o, sel_req_o, rx_bytes_o and all command outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| probe_req_i | input | 1 | Probe request pulse |
| use_aux_i | input | 1 | 1 selects the aux channel, 0 the bus channel |
| router_valid_i | input | 1 | Port router must be steered first |
| sel_ack_i | input | 1 | Port-select completed |
| sel_req_o | output | 1 | Port-select request |
| bus_start_o | output | 1 | Bus channel command start |
| bus_rd_o | output | 1 | Bus command is a read |
| bus_len_o | output | 8 | Bus command byte count |
| bus_addr_o | output | 7 | Bus command device address |
| bus_wdata_o | output | 8 | Bus command write byte |
| bus_done_i | input | 1 | Bus command finished |
| bus_err_i | input | 1 | Bus command failed (with done) |
| bus_rvalid_i | input | 1 | Bus read byte valid |
| bus_rdata_i | input | 8 | Bus read byte |
| aux_start_o | output | 1 | Aux channel command start |
| aux_rd_o | output | 1 | Aux command is a read |
| aux_len_o | output | 8 | Aux command byte count |
| aux_addr_o | output | 7 | Aux command device address |
| aux_wdata_o | output | 8 | Aux command write byte |
| aux_done_i | input | 1 | Aux command finished |
| aux_err_i | input | 1 | Aux command failed (with done) |
| aux_rvalid_i | input | 1 | Aux read byte valid |
| aux_rdata_i | input | 8 | Aux read byte |
| done_o | output | 1 | Probe finished pulse |
| present_o | output | 1 | Display present result |
| rx_bytes_o | output | 64 | Received bytes for debug |

## Verification
The bench builds the block with its defaults: device 0x50, an 8-byte read and a match threshold of 6. With these values the boundary between 6 and 5 matching bytes can be reached directly, as can the all-0xFF pattern that matches exactly 6 positions and the all-zero pattern that matches only 2. The bench's target model answers on either channel and can inject errors or a short read. While a command is pending, it also drives spurious done and err on the unselected channel, so that channel isolation is exercised under the same settings.

// File: rtl/ddc_probe_pkg.sv
package ddc_probe_pkg;
  localparam int CMD_LEN_W = 8;
  localparam int DEV_ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_WR_GO, ST_WR_WAIT, ST_RD_GO, ST_RD_WAIT, ST_EVAL
  } probe_st_e;

  typedef struct packed {
    logic                  start;
    logic                  rd;
    logic [CMD_LEN_W-1:0]  len;
    logic [DEV_ADDR_W-1:0] addr;
    logic [7:0]            wdata;
  } i2c_cmd_t;

  typedef struct packed {
    logic       done;
    logic       err;
    logic       rvalid;
    logic [7:0] rdata;
  } i2c_rsp_t;

  // identification header: zero at both ends, 0xFF in between
  function automatic logic [7:0] hdr_byte(input int idx, input int n);
    return (idx == 0 || idx == n - 1) ? 8'h00 : 8'hFF;
  endfunction
endpackage

// File: rtl/ddc_header_check.sv
module ddc_header_check
  import ddc_probe_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int MIN_MATCH = 6
) (
  input  logic [NUM_BYTES*8-1:0] bytes_i,
  output logic                   ok_o
);
  localparam int HIT_W = $clog2(NUM_BYTES + 1);

  logic [NUM_BYTES-1:0] hit;
  logic [HIT_W-1:0]     hits;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_cmp
    assign hit[g] = (bytes_i[g*8 +: 8] == hdr_byte(g, NUM_BYTES));
  end

  always_comb begin
    hits = '0;
    for (int i = 0; i < NUM_BYTES; i++) hits = hits + HIT_W'(hit[i]);
  end

  assign ok_o = (int'(hits) >= MIN_MATCH);
endmodule

// File: rtl/ddc_chan_mux.sv
module ddc_chan_mux
  import ddc_probe_pkg::*;
(
  input  logic     sel_aux_i,
  input  i2c_cmd_t cmd_i,
  output i2c_rsp_t rsp_o,
  output i2c_cmd_t bus_cmd_o,
  input  i2c_rsp_t bus_rsp_i,
  output i2c_cmd_t aux_cmd_o,
  input  i2c_rsp_t aux_rsp_i
);
  assign bus_cmd_o = sel_aux_i ? '0 : cmd_i;
  assign aux_cmd_o = sel_aux_i ? cmd_i : '0;
  assign rsp_o     = sel_aux_i ? aux_rsp_i : bus_rsp_i;
endmodule

// File: rtl/ddc_probe_fsm.sv
module ddc_probe_fsm
  import ddc_probe_pkg::*;
#(
  parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 7'h50,
  parameter int                    NUM_BYTES = 8,
  parameter logic [7:0]            OFFSET = 8'h00
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   use_aux_i,
  input  logic                   router_valid_i,
  input  logic                   sel_ack_i,
  input  logic                   hdr_ok_i,
  input  i2c_rsp_t               rsp_i,
  output logic                   sel_req_o,
  output logic                   aux_q_o,
  output i2c_cmd_t               cmd_o,
  output logic [NUM_BYTES*8-1:0] rx_o,
  output logic                   done_o,
  output logic                   present_o
);
  localparam int CNT_W = $clog2(NUM_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BYTES);

  probe_st_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      aux_q_o   <= 1'b0;
      cnt       <= '0;
      rx_o      <= '0;
      done_o    <= 1'b0;
      present_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_i) begin
          aux_q_o <= use_aux_i;
          st      <= router_valid_i ? ST_SEL : ST_WR_GO;
        end
        ST_SEL:  if (sel_ack_i) st <= ST_WR_GO;
        ST_WR_GO: st <= ST_WR_WAIT;
        ST_WR_WAIT: if (rsp_i.done) begin
          if (rsp_i.err) begin
            done_o    <= 1'b1;
            present_o <= 1'b0;
            st        <= ST_IDLE;
          end else st <= ST_RD_GO;
        end
        ST_RD_GO: begin
          cnt  <= '0;
          rx_o <= '0;
          st   <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rsp_i.rvalid && cnt < FULL) begin
            rx_o[int'(cnt)*8 +: 8] <= rsp_i.rdata;
            cnt <= cnt + 1'b1;
          end
          if (rsp_i.done) begin
            if (rsp_i.err || cnt != FULL) begin
              done_o    <= 1'b1;
              present_o <= 1'b0;
              st        <= ST_IDLE;
            end else st <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          done_o    <= 1'b1;
          present_o <= hdr_ok_i;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sel_req_o = (st == ST_SEL);

  always_comb begin
    cmd_o = '0;
    if (st == ST_WR_GO) begin
      cmd_o.start = 1'b1;
      cmd_o.len   = CMD_LEN_W'(1);
      cmd_o.addr  = DEV_ADDR;
      cmd_o.wdata = OFFSET;
    end else if (st == ST_RD_GO) begin
      cmd_o.start = 1'b1;
      cmd_o.rd    = 1'b1;
      cmd_o.len   = CMD_LEN_W'(NUM_BYTES);
      cmd_o.addr  = DEV_ADDR;
    end
  end
endmodule

// File: rtl/ddc_presence_probe.sv
module ddc_presence_probe
  import ddc_probe_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int          NUM_BYTES = 8,
  parameter int          MIN_MATCH = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   probe_req_i,
  input  logic                   use_aux_i,
  input  logic                   router_valid_i,
  input  logic                   sel_ack_i,
  output logic                   sel_req_o,
  output logic                   bus_start_o,
  output logic                   bus_rd_o,
  output logic [7:0]             bus_len_o,
  output logic [6:0]             bus_addr_o,
  output logic [7:0]             bus_wdata_o,
  input  logic                   bus_done_i,
  input  logic                   bus_err_i,
  input  logic                   bus_rvalid_i,
  input  logic [7:0]             bus_rdata_i,
  output logic                   aux_start_o,
  output logic                   aux_rd_o,
  output logic [7:0]             aux_len_o,
  output logic [6:0]             aux_addr_o,
  output logic [7:0]             aux_wdata_o,
  input  logic                   aux_done_i,
  input  logic                   aux_err_i,
  input  logic                   aux_rvalid_i,
  input  logic [7:0]             aux_rdata_i,
  output logic                   done_o,
  output logic                   present_o,
  output logic [NUM_BYTES*8-1:0] rx_bytes_o
);
  i2c_cmd_t cmd, bus_cmd, aux_cmd;
  i2c_rsp_t rsp, bus_rsp, aux_rsp;
  logic     aux_q, hdr_ok;

  assign bus_rsp = '{done: bus_done_i, err: bus_err_i, rvalid: bus_rvalid_i, rdata: bus_rdata_i};
  assign aux_rsp = '{done: aux_done_i, err: aux_err_i, rvalid: aux_rvalid_i, rdata: aux_rdata_i};

  ddc_probe_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES), .OFFSET(8'h00)) u_fsm (
    .clk_i, .rst_ni,
    .req_i(probe_req_i), .use_aux_i, .router_valid_i, .sel_ack_i,
    .hdr_ok_i(hdr_ok), .rsp_i(rsp),
    .sel_req_o, .aux_q_o(aux_q), .cmd_o(cmd),
    .rx_o(rx_bytes_o), .done_o, .present_o
  );

  ddc_chan_mux u_mux (
    .sel_aux_i(aux_q), .cmd_i(cmd), .rsp_o(rsp),
    .bus_cmd_o(bus_cmd), .bus_rsp_i(bus_rsp),
    .aux_cmd_o(aux_cmd), .aux_rsp_i(aux_rsp)
  );

  ddc_header_check #(.NUM_BYTES(NUM_BYTES), .MIN_MATCH(MIN_MATCH)) u_hdr (
    .bytes_i(rx_bytes_o), .ok_o(hdr_ok)
  );

  assign bus_start_o = bus_cmd.start;
  assign bus_rd_o    = bus_cmd.rd;
  assign bus_len_o   = bus_cmd.len;
  assign bus_addr_o  = bus_cmd.addr;
  assign bus_wdata_o = bus_cmd.wdata;
  assign aux_start_o = aux_cmd.start;
  assign aux_rd_o    = aux_cmd.rd;
  assign aux_len_o   = aux_cmd.len;
  assign aux_addr_o  = aux_cmd.addr;
  assign aux_wdata_o = aux_cmd.wdata;
endmodule

// File: rtl/ddc_presence_probe_chk.sv
module ddc_presence_probe_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_req_o,
  input logic       sel_ack_i,
  input logic       bus_start_o,
  input logic       bus_rd_o,
  input logic [7:0] bus_len_o,
  input logic [6:0] bus_addr_o,
  input logic [7:0] bus_wdata_o,
  input logic       aux_start_o,
  input logic       aux_rd_o,
  input logic [7:0] aux_len_o,
  input logic [6:0] aux_addr_o,
  input logic [7:0] aux_wdata_o,
  input logic       done_o,
  input logic       present_o
);
  a_r1_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_req_o && !sel_ack_i |=> sel_req_o);
  a_r1_no_start_in_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_req_o |-> !(bus_start_o || aux_start_o));
  a_r2_bus_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |-> bus_addr_o == DEV_ADDR);
  a_r2_aux_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_start_o |-> aux_addr_o == DEV_ADDR);
  a_r2_bus_wr_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o && !bus_rd_o |-> bus_len_o == 8'd1 && bus_wdata_o == 8'h00);
  a_r2_aux_wr_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_start_o && !aux_rd_o |-> aux_len_o == 8'd1 && aux_wdata_o == 8'h00);
  a_r6_one_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_start_o && aux_start_o));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_present_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(present_o) |-> done_o);
endmodule

bind ddc_presence_probe ddc_presence_probe_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (.*);

// File: tb/tb_ddc_presence_probe.sv
`timescale 1ns/1ps
module tb_ddc_presence_probe;
  logic clk_i = 0, rst_ni = 0;
  logic probe_req_i = 0, use_aux_i = 0, router_valid_i = 0, sel_ack_i = 0;
  logic sel_req_o;
  logic bus_start_o, bus_rd_o, aux_start_o, aux_rd_o;
  logic [7:0] bus_len_o, bus_wdata_o, aux_len_o, aux_wdata_o;
  logic [6:0] bus_addr_o, aux_addr_o;
  logic bus_done_i = 0, bus_err_i = 0, bus_rvalid_i = 0;
  logic aux_done_i = 0, aux_err_i = 0, aux_rvalid_i = 0;
  logic [7:0] bus_rdata_i = 0, aux_rdata_i = 0;
  logic done_o, present_o;
  logic [63:0] rx_bytes_o;

  ddc_presence_probe dut (.*);

  always #4 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  // target model knobs
  logic [63:0] k_data;
  logic k_wr_err = 0, k_rd_err = 0, k_rtr = 0;
  int   k_nsend = 8;
  int   n_bus = 0, n_aux = 0, shape_bad = 0, n_done = 0;
  bit   sel_seen = 0;

  typedef struct packed {
    logic [63:0] data;
    logic aux, rtr, wr_err, rd_err;
    logic [3:0] nsend;
    logic exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{64'h00FFFFFFFFFFFF00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1},  // exact, bus
    '{64'h00FFFFFFFFFFFF00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1},  // exact, aux
    '{64'h3412FFFFFFFFFF00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1},  // 6 match
    '{64'h3412FFFFFFFFFF01, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0},  // 5 match
    '{64'h00FFFFFFFFFFFF00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 1'b1},  // router
    '{64'h00FFFFFFFFFFFF00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8, 1'b0},  // write err
    '{64'h00FFFFFFFFFFFF00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8, 1'b0},  // read err
    '{64'h0000000000000000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0},  // 2 match
    '{64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1},  // 6 match
    '{64'h00FFFFFFFFFFFF00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 1'b0}   // short read
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // I2C target and port-select model; drives at negedge
  initial begin
    bit busy = 0, rd = 0, ch = 0;
    int sent = 0, wait_c = 0, sel_wait = 0;
    forever begin
      @(negedge clk_i);
      bus_done_i = 0; bus_err_i = 0; bus_rvalid_i = 0;
      aux_done_i = 0; aux_err_i = 0; aux_rvalid_i = 0;
      sel_ack_i = 0;
      if (sel_req_o) begin
        if (sel_wait == 0) sel_wait = 3;
        else begin
          sel_wait--;
          if (sel_wait == 0) begin sel_ack_i = 1; sel_seen = 1; end
        end
      end
      if (busy) begin
        // noise on the unselected channel
        if (ch) begin bus_done_i = 1; bus_err_i = 1; end
        else    begin aux_done_i = 1; aux_err_i = 1; end
        if (rd && sent < k_nsend && !k_rd_err) begin
          if (ch) begin aux_rvalid_i = 1; aux_rdata_i = k_data[sent*8 +: 8]; end
          else    begin bus_rvalid_i = 1; bus_rdata_i = k_data[sent*8 +: 8]; end
          sent++;
        end else if (wait_c > 0) wait_c--;
        else begin
          if (ch) begin aux_done_i = 1; aux_err_i = rd ? k_rd_err : k_wr_err; end
          else    begin bus_done_i = 1; bus_err_i = rd ? k_rd_err : k_wr_err; end
          busy = 0;
        end
      end else if (bus_start_o || aux_start_o) begin
        ch = aux_start_o;
        if (ch) begin
          n_aux++; rd = aux_rd_o;
          if (aux_addr_o != 7'h50 || aux_len_o != (rd ? 8'd8 : 8'd1) || (!rd && aux_wdata_o != 0)) shape_bad++;
        end else begin
          n_bus++; rd = bus_rd_o;
          if (bus_addr_o != 7'h50 || bus_len_o != (rd ? 8'd8 : 8'd1) || (!rd && bus_wdata_o != 0)) shape_bad++;
        end
        if (k_rtr && !sel_seen) shape_bad++;
        busy = 1; sent = 0; wait_c = 2;
      end
    end
  end

  always @(posedge clk_i) if (done_o) n_done++;

  task automatic run_probe(input logic aux, output bit got);
    got = 0;
    @(negedge clk_i);
    use_aux_i = aux; probe_req_i = 1;
    @(negedge clk_i);
    probe_req_i = 0;
    for (int c = 0; c < 300; c++) begin
      if (done_o) begin got = 1; break; end
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit got;
    logic [63:0] exp_rx;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(done_o == 0 && present_o == 0 && sel_req_o == 0 && rx_bytes_o == 0, "R10 reset outputs", {done_o, present_o, sel_req_o}, 0);
    chk(!bus_start_o && !aux_start_o && bus_addr_o == 0 && aux_len_o == 0, "R10 reset cmd", {bus_start_o, aux_start_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    for (int v = 0; v < 10; v++) begin
      k_data = VECS[v].data; k_wr_err = VECS[v].wr_err; k_rd_err = VECS[v].rd_err;
      k_rtr = VECS[v].rtr; k_nsend = int'(VECS[v].nsend);
      router_valid_i = VECS[v].rtr;
      n_bus = 0; n_aux = 0; shape_bad = 0; sel_seen = 0;
      run_probe(VECS[v].aux, got);
      chk(got, "R7 done seen", v, 0);
      chk(present_o == VECS[v].exp, "R4/R5/R3 present", present_o, VECS[v].exp);
      chk(shape_bad == 0, "R2/R1 command shape and order", shape_bad, 0);
      chk((VECS[v].aux ? n_bus : n_aux) == 0, "R6 unselected channel idle", VECS[v].aux ? n_bus : n_aux, 0);
      chk((VECS[v].aux ? n_aux : n_bus) == (VECS[v].wr_err ? 1 : 2), "R2/R3 command count",
          VECS[v].aux ? n_aux : n_bus, VECS[v].wr_err ? 1 : 2);
      if (VECS[v].rtr) chk(sel_seen, "R1 port select done", sel_seen, 1);
      if (!VECS[v].wr_err && !VECS[v].rd_err) begin
        exp_rx = 0;
        for (int b = 0; b < k_nsend; b++) exp_rx[b*8 +: 8] = k_data[b*8 +: 8];
        chk(rx_bytes_o == exp_rx, "R9 rx bytes", rx_bytes_o, exp_rx);
      end
      @(negedge clk_i);
      chk(done_o == 0, "R7 done one cycle", done_o, 0);
      repeat (3) @(negedge clk_i);
      chk(present_o == VECS[v].exp, "R7 present holds", present_o, VECS[v].exp);
    end
    router_valid_i = 0; k_rtr = 0;

    // R8: extra requests during a probe are ignored
    k_data = 64'h00FFFFFFFFFFFF00; k_wr_err = 0; k_rd_err = 0; k_nsend = 8;
    n_bus = 0; n_aux = 0; n_done = 0;
    @(negedge clk_i); use_aux_i = 0; probe_req_i = 1;
    @(negedge clk_i); probe_req_i = 0;
    repeat (3) @(negedge clk_i);
    probe_req_i = 1; use_aux_i = 1;
    @(negedge clk_i); probe_req_i = 0;
    repeat (6) @(negedge clk_i);
    probe_req_i = 1;
    @(negedge clk_i); probe_req_i = 0;
    repeat (60) @(negedge clk_i);
    chk(n_done == 1, "R8 single completion", n_done, 1);
    chk(n_bus == 2 && n_aux == 0, "R8 no extra commands", {n_bus, n_aux}, {32'd2, 32'd0});
    chk(present_o == 1, "R8 first probe result", present_o, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule